// File: doc/BRIEF.md
# Software Exception and Privilege Checker

This block sits beside the instruction decoder of a small RISC core. It inspects every decoded instruction word and reports four things. The first is whether the word raises one of the two exception opcodes: the 16-bit software exception or the 32-bit unimplemented-instruction trap. The second is whether the word is one of three operand-free special opcodes. The third is whether the instruction breaks the user/supervisor privilege rule or uses an illegal condition code. The fourth is the memory address of any system register it names. The decoder gives the checker an operation class, a condition field, a system-register number and the current mode and privilege-enable bits. The rest of the instruction decode, the datapath and the interrupt vectoring are left to the core.

Each instruction arrives on a valid/ready stream. A transfer takes place on a rising clock edge when `in_valid` and `in_ready` are both high. The result comes out on a second stream one cycle after the transfer, as `out_valid` plus a payload. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the result is held unchanged and new input is stalled. The block loses nothing and produces nothing of its own.

The cause codes written for an exception depend on a core-variant parameter. The privilege rule takes effect only while the privilege-enable input is high. A violation is reported twice: as a write-back kill bit inside the result, and as a separate one-cycle pulse.

Top module: `swexc_priv_checker`

## Requirements
- R1: A 16-bit word (`in_is32`=0) whose low half is 0x01E2 is a software exception. The result has `out_exc`=1 and `out_latch_idx`=1. `out_cause` is 4'b0001 when VARIANT=0 and 4'b1110 when VARIANT=1. The same bits presented as a 32-bit word raise nothing.
- R2: The 32-bit word 0x000F000F (`in_is32`=1) is the unimplemented-instruction exception. The result has `out_exc`=1 and `out_latch_idx`=1. `out_cause` is 4'b0100 when VARIANT=0 and 4'b1111 when VARIANT=1. Its low half presented as a 16-bit word raises nothing.
- R3: The 16-bit words 0x01F2, 0x0182 and 0x03C2 set `out_special` to 1 (sync), 2 (wired-and) and 3 (breakpoint). Every other word, and every 32-bit word, gives 0.
- R4: `in_cls` encodes 0 other, 1 global interrupt enable, 2 global interrupt disable, 3 return from interrupt, 4 system-register read, 5 system-register write and 6 conditional move. When `in_priv_en`=1 and `in_sup`=0, classes 1 to 5 are violations.
- R5: When `in_priv_en`=0, or when `in_sup`=1, classes 1 to 5 never cause a violation.
- R6: A conditional move (class 6) with `in_cond`=4'hF, the branch-and-link code, is a violation in every mode. Any other condition code is legal.
- R7: A violation sets `out_wb_kill` in the result. It also raises `viol_pulse` for exactly the first cycle in which that result is presented. `viol_pulse` is low at all other times.
- R8: For classes 4 and 5, `out_sreg_addr` = 0xF0400 + 4*(`in_sreg_num`+1): number 0 gives 0xF0404, number 1 gives 0xF0408 and number 2 gives 0xF040C. For every other class it is 0.
- R9: After reset, `out_valid` and `viol_pulse` are 0 and `in_ready` is 1. A result appears one cycle after its input transfer. No result appears while `in_valid` is low.
- R10: While `out_valid`=1 and `out_ready`=0, the result stays valid and unchanged and `in_ready`=0.
- R11: A result without an exception has `out_exc`=0, `out_cause`=0 and `out_latch_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Checker can take an instruction |
| in_word | input | 32 | Instruction word; 16-bit words in bits 15:0 |
| in_is32 | input | 1 | Word is a 32-bit instruction |
| in_cls | input | 3 | Operation class from the decoder |
| in_cond | input | 4 | Condition field of a conditional move |
| in_sreg_num | input | SREG_W | System-register number |
| in_priv_en | input | 1 | Privilege checking enabled (config bit 25) |
| in_sup | input | 1 | Supervisor mode (status bit 2) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_exc | output | 1 | Exception raised |
| out_latch_idx | output | LATCH_W | Interrupt-latch bit to set |
| out_cause | output | 4 | Exception cause code for the status register |
| out_special | output | 2 | Special opcode code |
| out_wb_kill | output | 1 | Suppress write-back |
| out_sreg_addr | output | ADDR_W | Mapped system-register address |
| viol_pulse | output | 1 | One-cycle violation pulse |

## Verification
The bench builds two copies of the block on the same stimulus: one with VARIANT=0 and one with VARIANT=1. With both variants running, every cause encoding is compared on each exception in a single run. All other parameters stay at their defaults. The width SREG_W=6 lets the bench reach the largest register number, 63, which maps to 0xF0500, alongside numbers 0 to 2. A periodic pattern on `out_ready` exercises the stall, hold and pulse timing.

// File: rtl/swexc_pkg.sv
package swexc_pkg;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_GIE     = 3'd1,
    CLS_GID     = 3'd2,
    CLS_RTI     = 3'd3,
    CLS_SREG_RD = 3'd4,
    CLS_SREG_WR = 3'd5,
    CLS_CMOV    = 3'd6
  } op_cls_e;

  typedef enum logic [1:0] {
    SPC_NONE  = 2'd0,
    SPC_SYNC  = 2'd1,
    SPC_WAND  = 2'd2,
    SPC_BKPT  = 2'd3
  } special_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_SOFT   = 2'd1,
    EXC_UNIMPL = 2'd2
  } exc_kind_e;

  localparam logic [15:0] OPC_SOFT_EXC = 16'h01E2;
  localparam logic [31:0] OPC_UNIMPL   = 32'h000F000F;
  localparam logic [15:0] OPC_SYNC     = 16'h01F2;
  localparam logic [15:0] OPC_WAND     = 16'h0182;
  localparam logic [15:0] OPC_BKPT     = 16'h03C2;

  // Cause code per core variant (0 or 1) and exception kind.
  function automatic logic [3:0] cause_of(input int variant, input exc_kind_e k);
    logic [3:0] c;
    c = 4'd0;
    if (k == EXC_SOFT)   c = (variant == 0) ? 4'b0001 : 4'b1110;
    if (k == EXC_UNIMPL) c = (variant == 0) ? 4'b0100 : 4'b1111;
    return c;
  endfunction

endpackage

// File: rtl/swexc_opcode_match.sv
module swexc_opcode_match
  import swexc_pkg::*;
(
  input  logic [31:0] word,
  input  logic        is32,
  output exc_kind_e   kind,
  output special_e    special
);

  localparam int N_SPC = 3;
  localparam logic [15:0] SPC_OPC [N_SPC] = '{OPC_SYNC, OPC_WAND, OPC_BKPT};

  logic [N_SPC-1:0] spc_hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_SPC; gi++) begin : g_spc
      assign spc_hit[gi] = !is32 && (word[15:0] == SPC_OPC[gi]);
    end
  endgenerate

  always_comb begin
    special = SPC_NONE;
    for (int i = 0; i < N_SPC; i++) begin
      if (spc_hit[i]) special = special_e'(2'(i + 1));
    end
  end

  always_comb begin
    kind = EXC_NONE;
    if (!is32 && word[15:0] == OPC_SOFT_EXC) kind = EXC_SOFT;
    else if (is32 && word == OPC_UNIMPL)     kind = EXC_UNIMPL;
  end

endmodule

// File: rtl/swexc_priv_check.sv
module swexc_priv_check
  import swexc_pkg::*;
#(
  parameter int                COND_W  = 4,
  parameter logic [COND_W-1:0] BL_COND = 4'hF
) (
  input  op_cls_e           cls,
  input  logic [COND_W-1:0] cond,
  input  logic              priv_en,
  input  logic              sup,
  output logic              priv_viol,
  output logic              cmov_bad
);

  logic restricted;
  logic guarded;

  assign restricted = priv_en && !sup;
  assign guarded    = cls inside {CLS_GIE, CLS_GID, CLS_RTI, CLS_SREG_RD, CLS_SREG_WR};
  assign priv_viol  = restricted && guarded;
  assign cmov_bad   = (cls == CLS_CMOV) && (cond == BL_COND);

endmodule

// File: rtl/swexc_sreg_map.sv
module swexc_sreg_map #(
  parameter int                SREG_W = 6,
  parameter int                ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE   = 20'hF0400
) (
  input  logic [SREG_W-1:0] num,
  input  logic              is_sreg,
  output logic [ADDR_W-1:0] addr
);

  localparam int STRIDE_SH = 2;

  logic [ADDR_W-1:0] slot;

  assign slot = ADDR_W'(num) + ADDR_W'(1);
  assign addr = is_sreg ? (BASE + (slot << STRIDE_SH)) : '0;

endmodule

// File: rtl/swexc_priv_checker.sv
module swexc_priv_checker
  import swexc_pkg::*;
#(
  parameter int                VARIANT   = 0,
  parameter int                SREG_W    = 6,
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] SREG_BASE = 20'hF0400,
  parameter int                LATCH_W   = 4,
  parameter int                EXC_BIT   = 1,
  parameter int                COND_W    = 4,
  parameter logic [COND_W-1:0] BL_COND   = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_word,
  input  logic               in_is32,
  input  logic [2:0]         in_cls,
  input  logic [COND_W-1:0]  in_cond,
  input  logic [SREG_W-1:0]  in_sreg_num,
  input  logic               in_priv_en,
  input  logic               in_sup,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_exc,
  output logic [LATCH_W-1:0] out_latch_idx,
  output logic [3:0]         out_cause,
  output logic [1:0]         out_special,
  output logic               out_wb_kill,
  output logic [ADDR_W-1:0]  out_sreg_addr,
  output logic               viol_pulse
);

  op_cls_e           cls;
  exc_kind_e         kind;
  special_e          special;
  logic              priv_viol;
  logic              cmov_bad;
  logic              is_sreg;
  logic [ADDR_W-1:0] sreg_addr;
  logic [3:0]        cause_soft;
  logic [3:0]        cause_unimpl;
  logic [3:0]        cause_nx;
  logic              viol_nx;
  logic              accept;

  assign cls     = op_cls_e'(in_cls);
  assign is_sreg = (cls == CLS_SREG_RD) || (cls == CLS_SREG_WR);

  swexc_opcode_match u_match (
    .word    (in_word),
    .is32    (in_is32),
    .kind    (kind),
    .special (special)
  );

  swexc_priv_check #(
    .COND_W  (COND_W),
    .BL_COND (BL_COND)
  ) u_priv (
    .cls       (cls),
    .cond      (in_cond),
    .priv_en   (in_priv_en),
    .sup       (in_sup),
    .priv_viol (priv_viol),
    .cmov_bad  (cmov_bad)
  );

  swexc_sreg_map #(
    .SREG_W (SREG_W),
    .ADDR_W (ADDR_W),
    .BASE   (SREG_BASE)
  ) u_map (
    .num     (in_sreg_num),
    .is_sreg (is_sreg),
    .addr    (sreg_addr)
  );

  // Cause encodings fixed at elaboration by the core variant.
  generate
    if (VARIANT == 0) begin : g_var_a
      assign cause_soft   = 4'b0001;
      assign cause_unimpl = 4'b0100;
    end else begin : g_var_b
      assign cause_soft   = 4'b1110;
      assign cause_unimpl = 4'b1111;
    end
  endgenerate

  always_comb begin
    unique case (kind)
      EXC_SOFT:   cause_nx = cause_soft;
      EXC_UNIMPL: cause_nx = cause_unimpl;
      default:    cause_nx = 4'd0;
    endcase
  end

  assign viol_nx  = priv_viol || cmov_bad;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      viol_pulse    <= 1'b0;
      out_exc       <= 1'b0;
      out_latch_idx <= '0;
      out_cause     <= '0;
      out_special   <= '0;
      out_wb_kill   <= 1'b0;
      out_sreg_addr <= '0;
    end else begin
      viol_pulse <= accept && viol_nx;
      if (accept) begin
        out_valid     <= 1'b1;
        out_exc       <= (kind != EXC_NONE);
        out_latch_idx <= (kind != EXC_NONE) ? LATCH_W'(EXC_BIT) : '0;
        out_cause     <= cause_nx;
        out_special   <= special;
        out_wb_kill   <= viol_nx;
        out_sreg_addr <= sreg_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/swexc_priv_checker_sva.sv
module swexc_priv_checker_sva
  import swexc_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int LATCH_W = 4,
  parameter int ADDR_W  = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [31:0]        in_word,
  input logic               in_is32,
  input logic [2:0]         in_cls,
  input logic               in_priv_en,
  input logic               in_sup,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_exc,
  input logic [LATCH_W-1:0] out_latch_idx,
  input logic [3:0]         out_cause,
  input logic [1:0]         out_special,
  input logic               out_wb_kill,
  input logic [ADDR_W-1:0]  out_sreg_addr,
  input logic               viol_pulse
);

  localparam logic [3:0] SOFT_CAUSE   = cause_of(VARIANT, EXC_SOFT);
  localparam logic [3:0] UNIMPL_CAUSE = cause_of(VARIANT, EXC_UNIMPL);

  // R1
  soft_exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_is32 && in_word[15:0] == 16'h01E2
    |=> out_valid && out_exc && out_cause == SOFT_CAUSE && out_latch_idx == LATCH_W'(1));

  // R2
  unimpl_exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_is32 && in_word == 32'h000F000F
    |=> out_valid && out_exc && out_cause == UNIMPL_CAUSE);

  // R5
  no_priv_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (!in_priv_en || in_sup) && in_cls != 3'd6
    |=> !viol_pulse);

  // R7
  pulse_with_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> out_valid && out_wb_kill);

  // R9
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (out_ready || !out_valid) |=> !out_valid);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready
    |=> out_valid && $stable(out_exc) && $stable(out_cause) && $stable(out_special)
        && $stable(out_wb_kill) && $stable(out_sreg_addr));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R11
  no_exc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_exc |-> out_cause == 4'd0 && out_latch_idx == '0);

endmodule

bind swexc_priv_checker swexc_priv_checker_sva #(
  .VARIANT (VARIANT),
  .LATCH_W (LATCH_W),
  .ADDR_W  (ADDR_W)
) u_sva (.*);

// File: tb/swexc_priv_checker_tb.sv
`timescale 1ns/1ps
module swexc_priv_checker_tb;

  typedef struct {
    logic        exc;
    logic [3:0]  idx;
    logic [3:0]  cause_a;
    logic [3:0]  cause_b;
    logic [1:0]  special;
    logic        viol;
    logic [19:0] addr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready, in_ready_b;
  logic [31:0] in_word;
  logic        in_is32;
  logic [2:0]  in_cls;
  logic [3:0]  in_cond;
  logic [5:0]  in_sreg_num;
  logic        in_priv_en;
  logic        in_sup;
  logic        out_valid, out_valid_b;
  logic        out_ready;
  logic        out_exc, out_exc_b;
  logic [3:0]  out_latch_idx, out_latch_idx_b;
  logic [3:0]  out_cause, out_cause_b;
  logic [1:0]  out_special, out_special_b;
  logic        out_wb_kill, out_wb_kill_b;
  logic [19:0] out_sreg_addr, out_sreg_addr_b;
  logic        viol_pulse, viol_pulse_b;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   bp       = 0;
  int   cyc      = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  swexc_priv_checker #(.VARIANT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_is32(in_is32), .in_cls(in_cls), .in_cond(in_cond),
    .in_sreg_num(in_sreg_num), .in_priv_en(in_priv_en), .in_sup(in_sup),
    .out_valid(out_valid), .out_ready(out_ready), .out_exc(out_exc),
    .out_latch_idx(out_latch_idx), .out_cause(out_cause), .out_special(out_special),
    .out_wb_kill(out_wb_kill), .out_sreg_addr(out_sreg_addr), .viol_pulse(viol_pulse)
  );

  swexc_priv_checker #(.VARIANT(1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_word(in_word), .in_is32(in_is32), .in_cls(in_cls), .in_cond(in_cond),
    .in_sreg_num(in_sreg_num), .in_priv_en(in_priv_en), .in_sup(in_sup),
    .out_valid(out_valid_b), .out_ready(out_ready), .out_exc(out_exc_b),
    .out_latch_idx(out_latch_idx_b), .out_cause(out_cause_b), .out_special(out_special_b),
    .out_wb_kill(out_wb_kill_b), .out_sreg_addr(out_sreg_addr_b), .viol_pulse(viol_pulse_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Expected result computed from the requirements.
  function automatic exp_t model(input logic [31:0] w, input logic is32, input logic [2:0] cls,
                                 input logic [3:0] cond, input logic [5:0] sn,
                                 input logic pe, input logic sup, input string tag);
    exp_t e;
    e.exc = 0; e.idx = 0; e.cause_a = 0; e.cause_b = 0; e.special = 0; e.tag = tag;
    if (!is32 && w[15:0] == 16'h01E2) begin
      e.exc = 1; e.idx = 1; e.cause_a = 4'b0001; e.cause_b = 4'b1110;
    end
    if (is32 && w == 32'h000F000F) begin
      e.exc = 1; e.idx = 1; e.cause_a = 4'b0100; e.cause_b = 4'b1111;
    end
    if (!is32 && w[15:0] == 16'h01F2) e.special = 2'd1;
    if (!is32 && w[15:0] == 16'h0182) e.special = 2'd2;
    if (!is32 && w[15:0] == 16'h03C2) e.special = 2'd3;
    e.viol = (pe && !sup && cls >= 3'd1 && cls <= 3'd5) || (cls == 3'd6 && cond == 4'hF);
    e.addr = (cls == 3'd4 || cls == 3'd5) ? 20'hF0400 + 20'(4 * (int'(sn) + 1)) : 20'h0;
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input logic is32, input logic [2:0] cls,
                      input logic [3:0] cond, input logic [5:0] sn,
                      input logic pe, input logic sup, input string tag);
    in_word = w; in_is32 = is32; in_cls = cls; in_cond = cond;
    in_sreg_num = sn; in_priv_en = pe; in_sup = sup; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q.push_back(model(w, is32, cls, cond, sn, pe, sup, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // out_ready driver: changes just after the rising edge.
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
    end
  end

  // Monitor / scoreboard.
  initial begin
    exp_t  e;
    bit    fresh;
    string r;
    fresh = 1;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected result", 32'(out_valid), 32'd0);
        end else begin
          e = q[0];
          r = out_ready ? e.tag : {e.tag, "/R10"};
          chk(out_exc == e.exc, r, "exc", 32'(out_exc), 32'(e.exc));
          chk(out_latch_idx == e.idx, r, "latch_idx", 32'(out_latch_idx), 32'(e.idx));
          chk(out_cause == e.cause_a, r, "cause A", 32'(out_cause), 32'(e.cause_a));
          chk(out_cause_b == e.cause_b, r, "cause B", 32'(out_cause_b), 32'(e.cause_b));
          chk(out_special == e.special, r, "special", 32'(out_special), 32'(e.special));
          chk(out_wb_kill == e.viol, r, "wb_kill", 32'(out_wb_kill), 32'(e.viol));
          chk(out_sreg_addr == e.addr, r, "sreg_addr", 32'(out_sreg_addr), 32'(e.addr));
          // R7: pulse only in the first presentation cycle.
          chk(viol_pulse == (fresh && e.viol), "R7", "viol_pulse",
              32'(viol_pulse), 32'(fresh && e.viol));
          if (!out_ready) chk(!in_ready, "R10", "in_ready during stall", 32'(in_ready), 32'd0);
          if (out_ready) begin
            void'(q.pop_front());
            fresh = 1;
          end else begin
            fresh = 0;
          end
        end
      end else if (rst_n === 1'b1 && viol_pulse) begin
        chk(0, "R7", "pulse with no result", 32'(viol_pulse), 32'd0);
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_is32 = 1'b0; in_cls = '0;
    in_cond = '0; in_sreg_num = '0; in_priv_en = 1'b0; in_sup = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 0, "R9", "out_valid after reset", 32'(out_valid), 32'd0);
    chk(viol_pulse == 0, "R9", "viol_pulse after reset", 32'(viol_pulse), 32'd0);
    chk(in_ready == 1, "R9", "in_ready after reset", 32'(in_ready), 32'd1);

    for (int pass = 0; pass < 2; pass++) begin
      bp = (pass == 1);
      send(32'h0000_01E2, 0, 3'd0, 4'h0, 6'd0, 0, 0, "R1");
      send(32'hABCD_01E2, 0, 3'd0, 4'h0, 6'd0, 1, 0, "R1");
      send(32'h0000_01E2, 1, 3'd0, 4'h0, 6'd0, 0, 0, "R1");
      send(32'h000F_000F, 1, 3'd0, 4'h0, 6'd0, 0, 0, "R2");
      send(32'h000F_000F, 0, 3'd0, 4'h0, 6'd0, 0, 0, "R2");
      send(32'h0000_01F2, 0, 3'd0, 4'h0, 6'd0, 0, 0, "R3");
      send(32'h0000_0182, 0, 3'd0, 4'h0, 6'd0, 0, 0, "R3");
      send(32'h0000_03C2, 0, 3'd0, 4'h0, 6'd0, 0, 0, "R3");
      send(32'h0000_03C2, 1, 3'd0, 4'h0, 6'd0, 0, 0, "R3");
      send(32'h0000_1234, 0, 3'd0, 4'h0, 6'd0, 0, 0, "R11");
      send(32'h0000_0000, 0, 3'd1, 4'h0, 6'd0, 1, 0, "R4");
      send(32'h0000_0000, 0, 3'd2, 4'h0, 6'd0, 1, 0, "R4");
      send(32'h0000_0000, 0, 3'd3, 4'h0, 6'd0, 1, 0, "R4");
      send(32'h0000_0000, 1, 3'd4, 4'h0, 6'd1, 1, 0, "R4");
      send(32'h0000_0000, 1, 3'd5, 4'h0, 6'd2, 1, 0, "R4");
      send(32'h0000_0000, 0, 3'd1, 4'h0, 6'd0, 0, 0, "R5");
      send(32'h0000_0000, 0, 3'd3, 4'h0, 6'd0, 1, 1, "R5");
      send(32'h0000_0000, 1, 3'd5, 4'h0, 6'd0, 1, 1, "R5");
      send(32'h0000_0000, 0, 3'd6, 4'hF, 6'd0, 0, 0, "R6");
      send(32'h0000_0000, 0, 3'd6, 4'hF, 6'd0, 1, 1, "R6");
      send(32'h0000_0000, 0, 3'd6, 4'h0, 6'd0, 1, 0, "R6");
      send(32'h0000_0000, 0, 3'd6, 4'hE, 6'd0, 0, 0, "R6");
      send(32'h0000_0000, 1, 3'd4, 4'h0, 6'd0, 0, 0, "R8");
      send(32'h0000_0000, 1, 3'd5, 4'h0, 6'd63, 0, 1, "R8");
      send(32'h0000_0000, 1, 3'd0, 4'h0, 6'd7, 0, 0, "R8");
      // back-to-back violations, then an idle gap
      send(32'h0000_0000, 0, 3'd6, 4'hF, 6'd0, 0, 0, "R7");
      send(32'h0000_0000, 0, 3'd2, 4'h0, 6'd0, 1, 0, "R7");
      repeat (3) @(negedge clk);
    end

    bp = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    // R9 nothing appears while in_valid stays low
    chk(out_valid == 0, "R9", "out_valid while idle", 32'(out_valid), 32'd0);
    chk(q.size() == 0, "R9", "results outstanding", 32'(q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule